// File: doc/BRIEF.md
# Encoded Interrupt Level Synchronizer

This block sits between four asynchronous interrupt-level pins and the integer unit of a processor core. An external circuit has already ranked the interrupt sources and drives the winning level onto the pins as a 4-bit code. The block brings that code into the core's clock domain. It samples the pins on the falling edge of the clock through a two-flop synchronizer. It accepts a value only when two consecutive falling-edge samples are equal, so a value that the pins show for one clock period is never taken.

An accepted level is latched and presented to the core. It stays there, whatever the pins do afterwards, until the core returns an acknowledge. Code zero means that no interrupt is pending and is never latched. The all-ones code is the non-maskable interrupt and always raises a request. Every other code is maskable and raises a request only while it is strictly greater than the core's current processor interrupt level.

Top module: `irq_level_sync`

## Requirements
- R1: While reset is asserted and just after it is released, `irq_level` is 0 and `irq_req` and `irq_nmi` are 0.
- R2: A nonzero code driven onto `irq_pins` just after a rising edge is not visible two rising edges later. It appears on `irq_level` after the third rising edge, which follows two falling-edge synchronizer stages and one agreeing comparison.
- R3: A code that the pins show for only one clock period is never accepted, so `irq_level` stays 0.
- R4: Code 0 (no interrupt) is never latched. While the pins hold 0, `irq_level`, `irq_req` and `irq_nmi` stay 0.
- R5: Once a level is latched, later changes on `irq_pins` do not alter `irq_level` until an acknowledge.
- R6: `irq_ack` high at a rising edge while a level is held clears `irq_level` to 0 at that edge. If the pins have already returned to 0, nothing is latched again.
- R7: A latched maskable code (1 to 14) is shown on `irq_level`. `irq_req` is 1 only while that code is strictly greater than `cpu_pil`, and it follows changes of `cpu_pil` in the same cycle.
- R8: A latched code 15 drives `irq_nmi` to 1 and `irq_req` to 1 for any value of `cpu_pil`. `irq_nmi` is 0 for every other code.
- R9: `irq_ack` while no level is held has no effect: outputs stay 0 and a later level is accepted with the R2 latency.
- R10: If the pins still hold a stable nonzero code when an acknowledge clears the level, that code is latched again at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; pins are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | 4 | Encoded interrupt level from the pins, asynchronous |
| cpu_pil | input | 4 | Current processor interrupt level (mask threshold) |
| irq_ack | input | 1 | Core acknowledge of the held level |
| irq_level | output | 4 | Held level, 0 when nothing is held |
| irq_req | output | 1 | Interrupt request to the integer unit |
| irq_nmi | output | 1 | Held level is the non-maskable code |

## Verification
On every cycle, the assertions check the following. A non-maskable flag always comes with a request. No request is raised at level zero. A held level stays stable until an acknowledge. An acknowledge clears the level on the next edge. A latch event loads exactly the agreed candidate code. Some behaviours only the bench scenarios can show: the exact three-edge acceptance latency, the rejection of one-period glitches, the strict-greater masking against `cpu_pil`, recapture after an acknowledge, and an idle acknowledge having no effect. Each of these depends on a specific sequence of pin values over several clock edges.

// File: rtl/irq_sync_pkg.sv
package irq_sync_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_NONE = '0;
  localparam lvl_t LVL_NMI  = '1;

  // Code carries the non-maskable meaning.
  function automatic logic lvl_is_nmi(lvl_t l);
    return l == LVL_NMI;
  endfunction

  // Code should raise a request against the given mask threshold.
  function automatic logic lvl_wins(lvl_t l, lvl_t pil);
    return lvl_is_nmi(l) || ((l != LVL_NONE) && (l > pil));
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync
  import irq_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  lvl_t pins,
  output lvl_t cand_level,
  output logic cand_stable
);
  lvl_t stage_q [SYNC_STAGES];
  lvl_t prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(negedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= LVL_NONE;
          else        stage_q[0] <= pins;
        end
      end else begin : g_next
        always_ff @(negedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= LVL_NONE;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  // Previous falling-edge sample for the agreement test
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= LVL_NONE;
    else        prev_q <= stage_q[SYNC_STAGES-1];
  end

  assign cand_level  = stage_q[SYNC_STAGES-1];
  assign cand_stable = (stage_q[SYNC_STAGES-1] == prev_q);
endmodule

// File: rtl/irq_level_hold.sv
module irq_level_hold
  import irq_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_t cand_level,
  input  logic cand_stable,
  input  logic ack,
  output lvl_t held_level,
  output logic held_valid,
  output logic take_evt,
  output logic clear_evt
);
  lvl_t level_q;
  logic valid_q;

  assign take_evt  = !valid_q && cand_stable && (cand_level != LVL_NONE);
  assign clear_evt = valid_q && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_NONE;
      valid_q <= 1'b0;
    end else if (clear_evt) begin
      level_q <= LVL_NONE;
      valid_q <= 1'b0;
    end else if (take_evt) begin
      level_q <= cand_level;
      valid_q <= 1'b1;
    end
  end

  assign held_level = level_q;
  assign held_valid = valid_q;
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
  import irq_sync_pkg::*;
(
  input  lvl_t held_level,
  input  logic held_valid,
  input  lvl_t pil,
  output lvl_t level_out,
  output logic req,
  output logic nmi
);
  assign level_out = held_valid ? held_level : LVL_NONE;
  assign nmi       = held_valid && lvl_is_nmi(held_level);
  assign req       = held_valid && lvl_wins(held_level, pil);
endmodule

// File: rtl/irq_level_sync.sv
module irq_level_sync
  import irq_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] irq_pins,
  input  logic [LVL_W-1:0] cpu_pil,
  input  logic             irq_ack,
  output logic [LVL_W-1:0] irq_level,
  output logic             irq_req,
  output logic             irq_nmi
);
  lvl_t cand_level;
  logic cand_stable;
  lvl_t held_level;
  logic held_valid;
  logic take_evt;
  logic clear_evt;

  irq_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins(irq_pins),
    .cand_level(cand_level), .cand_stable(cand_stable)
  );

  irq_level_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cand_level(cand_level),
    .cand_stable(cand_stable), .ack(irq_ack),
    .held_level(held_level), .held_valid(held_valid),
    .take_evt(take_evt), .clear_evt(clear_evt)
  );

  irq_req_gen u_req (
    .held_level(held_level), .held_valid(held_valid), .pil(cpu_pil),
    .level_out(irq_level), .req(irq_req), .nmi(irq_nmi)
  );
endmodule

// File: rtl/irq_level_sync_chk.sv
module irq_level_sync_chk
  import irq_sync_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input lvl_t irq_level,
  input logic irq_req,
  input logic irq_nmi,
  input logic irq_ack,
  input lvl_t cand_level,
  input logic take_evt,
  input logic clear_evt
);
  assert_nmi_implies_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nmi |-> irq_req);

  assert_no_req_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == LVL_NONE) |-> (!irq_req && !irq_nmi));

  assert_level_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_level != LVL_NONE) && !irq_ack) |=> $stable(irq_level));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (irq_level == LVL_NONE));

  assert_take_loads_candidate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> (irq_level == $past(cand_level)));
endmodule

bind irq_level_sync irq_level_sync_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .irq_req(irq_req),
  .irq_nmi(irq_nmi), .irq_ack(irq_ack), .cand_level(cand_level),
  .take_evt(take_evt), .clear_evt(clear_evt)
);

// File: tb/irq_level_sync_test.sv
module irq_level_sync_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_pins = 4'd0;
  logic [3:0] cpu_pil = 4'd0;
  logic       irq_ack = 1'b0;
  logic [3:0] irq_level;
  logic       irq_req;
  logic       irq_nmi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_level_sync uut (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .cpu_pil(cpu_pil),
    .irq_ack(irq_ack), .irq_level(irq_level), .irq_req(irq_req), .irq_nmi(irq_nmi)
  );

  // {pins, pil, expected level, expected req, expected nmi}
  localparam logic [13:0] VECS [8] = '{
    {4'd3,  4'd0,  4'd3,  1'b1, 1'b0},
    {4'd5,  4'd7,  4'd5,  1'b0, 1'b0},
    {4'd5,  4'd5,  4'd5,  1'b0, 1'b0},
    {4'd6,  4'd5,  4'd6,  1'b1, 1'b0},
    {4'd14, 4'd13, 4'd14, 1'b1, 1'b0},
    {4'd1,  4'd0,  4'd1,  1'b1, 1'b0},
    {4'd15, 4'd15, 4'd15, 1'b1, 1'b1},
    {4'd0,  4'd0,  4'd0,  1'b0, 1'b0}
  };

  // Independent model of the request rule
  function automatic logic want_req(logic [3:0] l, logic [3:0] p);
    if (l == 4'd0) return 1'b0;
    if (l == 4'd15) return 1'b1;
    return l > p;
  endfunction

  // Advance n rising edges and land 1 ns after the last one
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string req, logic [3:0] el, logic er, logic en);
    checks++;
    if (irq_level !== el || irq_req !== er || irq_nmi !== en) begin
      errors++;
      $display("FAIL %s: level=%0d req=%0b nmi=%0b expected level=%0d req=%0b nmi=%0b",
               req, irq_level, irq_req, irq_nmi, el, er, en);
    end
  endtask

  // Acknowledge with the pins returning to zero, then let the pipeline settle
  task automatic ack_and_idle();
    irq_ack = 1'b1;
    irq_pins = 4'd0;
    tick(1);
    irq_ack = 1'b0;
    tick(4);
  endtask

  initial begin
    expect_out("R1", 4'd0, 1'b0, 1'b0);
    tick(3);
    expect_out("R1", 4'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick(3);
    expect_out("R1", 4'd0, 1'b0, 1'b0);

    // Table walk: R7, R8, R4 and R6
    for (int i = 0; i < 8; i++) begin
      logic [3:0] vp, vl;
      logic vr, vn;
      {vp, cpu_pil, vl, vr, vn} = VECS[i];
      irq_pins = vp;
      if (vr !== want_req(vl, cpu_pil)) $display("table entry %0d inconsistent", i);
      tick(3);
      expect_out(vp == 4'd15 ? "R8" : (vp == 4'd0 ? "R4" : "R7"), vl, vr, vn);
      ack_and_idle();
      expect_out("R6", 4'd0, 1'b0, 1'b0);
    end

    // R2: exact latency
    cpu_pil = 4'd0;
    irq_pins = 4'd9;
    tick(2);
    expect_out("R2", 4'd0, 1'b0, 1'b0);
    tick(1);
    expect_out("R2", 4'd9, 1'b1, 1'b0);

    // R5: pin changes ignored while held
    irq_pins = 4'd2;
    tick(4);
    expect_out("R5", 4'd9, 1'b1, 1'b0);
    irq_pins = 4'd15;
    tick(4);
    expect_out("R5", 4'd9, 1'b1, 1'b0);

    // R7: mask threshold follows cpu_pil in the same cycle
    cpu_pil = 4'd9;
    #1;
    expect_out("R7", 4'd9, 1'b0, 1'b0);
    cpu_pil = 4'd8;
    #1;
    expect_out("R7", 4'd9, 1'b1, 1'b0);
    tick(1);

    // R10: ack with pins held stable at 4 recaptures one edge later
    irq_pins = 4'd4;
    tick(4);
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    expect_out("R10", 4'd0, 1'b0, 1'b0);
    tick(1);
    expect_out("R10", 4'd4, 1'b0, 1'b0);
    ack_and_idle();

    // R3: one-period glitches never accepted
    cpu_pil = 4'd0;
    irq_pins = 4'd7;
    tick(1);
    irq_pins = 4'd0;
    tick(5);
    expect_out("R3", 4'd0, 1'b0, 1'b0);
    irq_pins = 4'd11;
    tick(1);
    irq_pins = 4'd12;
    tick(1);
    irq_pins = 4'd13;
    tick(1);
    irq_pins = 4'd0;
    tick(5);
    expect_out("R3", 4'd0, 1'b0, 1'b0);

    // R4: zero held steadily
    tick(6);
    expect_out("R4", 4'd0, 1'b0, 1'b0);

    // R9: ack while idle has no effect
    irq_ack = 1'b1;
    tick(2);
    expect_out("R9", 4'd0, 1'b0, 1'b0);
    irq_ack = 1'b0;
    irq_pins = 4'd10;
    tick(2);
    expect_out("R9", 4'd0, 1'b0, 1'b0);
    tick(1);
    expect_out("R9", 4'd10, 1'b1, 1'b0);
    ack_and_idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule